// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

This block is the combinational integer datapath unit of a 32-bit base-integer RISC-V core. It takes two operands and a 4-bit operation code. It returns a 32-bit result and a flag that is high when that result is zero. It adds and subtracts, applies bitwise AND, OR and XOR, and performs logical-left, logical-right and arithmetic-right shifts. It also provides signed and unsigned set-less-than.

The decoder and the operand multiplexers sit outside the block. The register-register and register-immediate forms of an instruction therefore use the same operation code. The only difference is what is driven onto operand B. No register sits on any path, so the outputs settle in the same cycle as the inputs.

Top module: `rv_int_alu`

## Requirements
- R1: Code 4'd0 (add) gives `opnd_a + opnd_b` modulo 2^32, and a carry out of bit 31 is discarded without any indication.
- R2: Code 4'd1 (subtract) gives `opnd_a - opnd_b` modulo 2^32, and a borrow wraps without any indication.
- R3: Codes 4'd2, 4'd3 and 4'd4 give the bitwise AND, OR and XOR of the two operands.
- R4: Code 4'd5 shifts `opnd_a` left by `opnd_b[4:0]` places and fills the vacated low bits with 0.
- R5: Code 4'd6 shifts `opnd_a` right by `opnd_b[4:0]` places and fills the vacated high bits with 0.
- R6: Code 4'd7 shifts `opnd_a` right by `opnd_b[4:0]` places and fills the vacated high bits with `opnd_a[31]`.
- R7: For the three shift codes, `opnd_b[31:5]` has no effect on the result.
- R8: Code 4'd8 returns 32'd1 when `opnd_a` is less than `opnd_b`, both read as two's-complement numbers, and 32'd0 otherwise.
- R9: Code 4'd9 returns 32'd1 when `opnd_a` is less than `opnd_b`, both read as unsigned numbers, and 32'd0 otherwise.
- R10: Codes 4'd10 to 4'd15 return a result of 32'd0.
- R11: `zero` is 1 exactly when `result` equals 32'h0.
- R12: `result` and `zero` follow the inputs with no clock and no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the value that is shifted for shift codes |
| opnd_b | input | 32 | Second operand; bits [4:0] give the shift distance |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The immediate assertions inside the sub-units are skipped whenever an input carries X or Z. They therefore assume the core always presents fully known operands and codes. The comparison check in the add/subtract unit assumes the unit is in subtract mode when its less-than outputs are used. The top module guarantees this for both set-less-than codes. The bench drives only known values and changes them between clock edges. It uses all sixteen codes, including the unused ones, so every path through the result selector is exercised with legal input.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  localparam int XLEN    = 32;
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9
  } alu_op_e;
endpackage

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W:0]   ext;
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = ext[W-1:0];
    // In subtract mode a missing carry out means a borrow: a < b unsigned.
    lt_u  = ~ext[W];
    // If the sign bits differ, a is the smaller one when a is negative.
    lt_s  = (a[W-1] ^ b[W-1]) ? a[W-1] : ext[W-1];
  end

  always_comb begin
    if (!$isunknown({a, b, sub})) begin
      if (!sub) begin
        // R1
        add_wrap_chk: assert (sum == W'(a + b));
      end else begin
        // R2
        sub_wrap_chk: assert (sum == W'(a - b));
        // R9
        ltu_chk: assert (lt_u == (a < b));
        // R8
        lts_chk: assert (lt_s == ($signed(a) < $signed(b)));
      end
    end
  end
endmodule

// File: rtl/rv_alu_logic.sv
module rv_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y_and,
  output logic [W-1:0] y_or,
  output logic [W-1:0] y_xor
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_and[i] = a[i] & b[i];
    assign y_or[i]  = a[i] | b[i];
    assign y_xor[i] = a[i] ^ b[i];
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R3
      logic_id_chk: assert ((y_xor | y_and) == y_or);
    end
  end
endmodule

// File: rtl/rv_alu_shift.sv
module rv_alu_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  y
);
  logic [W-1:0] a_rev;
  logic [W-1:0] src;
  logic [W-1:0] stg [SW+1];
  logic [W-1:0] res_rev;
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign a_rev[i] = a[W-1-i];
  end

  assign src    = left ? a_rev : a;
  assign fill   = arith & ~left & a[W-1];
  assign stg[0] = src;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign res_rev[i] = stg[SW][W-1-i];
  end

  assign y = left ? res_rev : stg[SW];

  always_comb begin
    if (!$isunknown({a, amt, left, arith})) begin
      if (left) begin
        // R4
        sll_chk: assert (y == (a << amt));
      end else if (arith) begin
        // R6
        sra_chk: assert (y == W'($signed(a) >>> amt));
      end else begin
        // R5
        srl_chk: assert (y == (a >> amt));
      end
    end
  end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
  import rv_alu_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int OPW  = OP_W
) (
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [OPW-1:0] op_sel,
  output logic [W-1:0]   result,
  output logic           zero
);
  localparam int SW = $clog2(W);

  logic [W-1:0] as_sum, sh_y, l_and, l_or, l_xor;
  logic         as_sub, lt_s, lt_u, sh_left, sh_arith;

  // Subtract mode is also used by both comparisons.
  assign as_sub   = (op_sel == OP_SUB) || (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign sh_left  = (op_sel == OP_SLL);
  assign sh_arith = (op_sel == OP_SRA);

  rv_alu_addsub #(.W(W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(as_sub),
    .sum(as_sum), .lt_s(lt_s), .lt_u(lt_u)
  );

  rv_alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b),
    .y_and(l_and), .y_or(l_or), .y_xor(l_xor)
  );

  // R7: only the low SW bits of operand B reach the shifter.
  rv_alu_shift #(.W(W), .SW(SW)) u_shift (
    .a(opnd_a), .amt(opnd_b[SW-1:0]), .left(sh_left), .arith(sh_arith),
    .y(sh_y)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB:   result = as_sum;
      OP_AND:           result = l_and;
      OP_OR:            result = l_or;
      OP_XOR:           result = l_xor;
      OP_SLL, OP_SRL,
      OP_SRA:           result = sh_y;
      OP_SLT:           result = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:          result = {{(W-1){1'b0}}, lt_u};
      default:          result = '0;
    endcase
  end

  assign zero = (result == '0);

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
      if (op_sel > OPW'(OP_SLTU)) begin
        // R10
        unused_op_chk: assert (result == '0 && zero);
      end
      if (op_sel == OP_SLT || op_sel == OP_SLTU) begin
        // R8
        slt_width_chk: assert (result[W-1:1] == '0);
      end
    end
  end
endmodule

// File: tb/test_rv_int_alu.sv
`timescale 1ns/1ps
module test_rv_int_alu;
  logic        clk;
  logic        rst_n;
  logic [31:0] opnd_a, opnd_b;
  logic [3:0]  op_sel;
  logic [31:0] result;
  logic        zero;
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  rv_int_alu i_rv_int_alu (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
    .result(result), .zero(zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] op,
                                        input logic [31:0] a,
                                        input logic [31:0] b);
    logic [4:0] s;
    s = b[4:0];
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return a << s;
      4'd6: return a >> s;
      4'd7: return 32'($signed(a) >>> s);
      4'd8: return {31'd0, $signed(a) < $signed(b)};
      4'd9: return {31'd0, a < b};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
               req, op_sel, opnd_a, opnd_b, got, exp);
    end
  endtask

  // Drive away from the edge, sample one ns later; checks R12 and R11 too.
  task automatic apply(input string req, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] e;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    #1;
    e = model(op, a, b);
    check(req, result, e);
    check("R11", {31'd0, zero}, {31'd0, e == 32'd0});
  endtask

  task automatic t_idle;
    apply("R12", 4'd0, 32'd0, 32'd0);
  endtask

  task automatic t_add;
    apply("R1", 4'd0, 32'd5, 32'd7);
    apply("R1", 4'd0, 32'hFFFF_FFFF, 32'd1);
    apply("R1", 4'd0, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_sub;
    apply("R2", 4'd1, 32'd10, 32'd3);
    apply("R2", 4'd1, 32'd0, 32'd1);
    apply("R2", 4'd1, 32'h1234_5678, 32'h1234_5678);
  endtask

  task automatic t_logic;
    apply("R3", 4'd2, 32'hF0F0_1234, 32'h0FF0_FF00);
    apply("R3", 4'd3, 32'hF0F0_1234, 32'h0FF0_FF00);
    apply("R3", 4'd4, 32'hF0F0_1234, 32'h0FF0_FF00);
    apply("R3", 4'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
  endtask

  task automatic t_shift;
    apply("R4", 4'd5, 32'h8000_0001, 32'd0);
    apply("R4", 4'd5, 32'h0000_0003, 32'd31);
    apply("R5", 4'd6, 32'h8000_0000, 32'd31);
    apply("R5", 4'd6, 32'hF000_000F, 32'd4);
    apply("R6", 4'd7, 32'h8000_0000, 32'd31);
    apply("R6", 4'd7, 32'hF000_000F, 32'd4);
    apply("R6", 4'd7, 32'h7000_0000, 32'd4);
  endtask

  task automatic t_shamt_mask;
    apply("R7", 4'd5, 32'h0000_0001, 32'hFFFF_FFE3);
    apply("R7", 4'd6, 32'h8000_0000, 32'h0000_0020);
    apply("R7", 4'd7, 32'h8000_0000, 32'h1234_5661);
  endtask

  task automatic t_compare;
    apply("R8", 4'd8, 32'hFFFF_FFFF, 32'd1);
    apply("R8", 4'd8, 32'd1, 32'hFFFF_FFFF);
    apply("R8", 4'd8, 32'h8000_0000, 32'h7FFF_FFFF);
    apply("R8", 4'd8, 32'd7, 32'd7);
    apply("R9", 4'd9, 32'hFFFF_FFFF, 32'd1);
    apply("R9", 4'd9, 32'd1, 32'hFFFF_FFFF);
    apply("R9", 4'd9, 32'd7, 32'd7);
    apply("R9", 4'd9, 32'd0, 32'd1);
  endtask

  task automatic t_unused;
    for (int c = 10; c < 16; c++)
      apply("R10", 4'(c), 32'hDEAD_BEEF, 32'h0000_0001);
  endtask

  task automatic t_sweep;
    logic [31:0] x, y;
    x = 32'h1357_9BDF;
    y = 32'h2468_ACE0;
    for (int n = 0; n < 200; n++) begin
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      y = y * 32'd1103515245 + 32'd12345;
      apply("R1", 4'(n % 16), x, y);
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    op_sel = 4'd0; opnd_a = 32'd0; opnd_b = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_shamt_mask();
    t_compare();
    t_unused();
    t_sweep();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule